// File: doc/BRIEF.md
# Bitplane Fetch Window Controller

This block decides, slot by slot, when a raster display's bitplane fetch engine may use memory during a scan line. A horizontal slot counter drives it, along with three configuration values: the first fetch slot, the last slot at which a fetch unit may still begin, and a unit-size code that selects 8, 16 or 32 slots per unit. From these it produces a run signal that covers the fetch window and an enable that marks the slots in which data is actually moved.

Units are laid end to end from the start slot. Each unit fetches its data in its first eight slots. In the wide modes, the remaining slots of a unit are part of the run but move no data. The final unit keeps the run high only for those eight data slots. Because of this, a stop value at the far right of the line still lets the run end before the line does, and it cannot carry over into the next line. Configuration is sampled once per line, on the line-start slot.

The controller is a four-state machine:
- `FW_DONE`: no fetch for the rest of the line. This is also the state after reset.
- `FW_WAIT`: waiting for the start slot.
- `FW_UNIT`: inside a unit that is not the last.
- `FW_LAST`: inside the shortened final unit.

Transitions:
- Slot 0 in any state leads to `FW_WAIT`.
- `FW_WAIT` leads to `FW_UNIT` or `FW_LAST` at the start slot, if the start is not past the stop.
- `FW_UNIT` leads to `FW_UNIT` or `FW_LAST` on the last slot of a unit.
- `FW_LAST` leads to `FW_DONE` after its eighth slot.

Top module: `fw_ctrl`

## Requirements
- R1: A line holds slots 0x00 to 0xE1, and slot 0 marks the line start. `fetch_run` is never high for a slot at or beyond 0xE2.
- R2: The unit-size code selects the unit length: 0 gives 8 slots, 1 gives 16 slots, and 2 or 3 give 32 slots.
- R3: A start value below 0x18 is treated as 0x18, and no run occurs for any slot before 0x18.
- R4: A stop value above 0xD8 is treated as 0xD8.
- R5: The first unit begins at the start slot, and each later unit begins exactly one unit length after the previous one. A unit begins only if its first slot is at or below the stop value.
- R6: A unit that is not the final one keeps `fetch_run` high for its full length. The final unit keeps it high for only 8 slots. With 16-slot units, start 0x18 and stop 0xD8, the last run slot is 0xDF and slot 0xE0 is idle.
- R7: `fetch_slot_en` is high on the first 8 slots of every unit and low on all other slots. It is never high without `fetch_run`.
- R8: If the start value after clamping exceeds the stop value after clamping, no fetch occurs on that line.
- R9: Start, stop and unit size are sampled only on the slot-0 edge. A change during a line has no effect until the next line.
- R10: The outputs after the clock edge that samples slot s describe slot s. For slot 0 they are always low.
- R11: After reset both outputs are low, and they stay low until a slot 0 has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_pos | input | 8 | Horizontal slot counter, 0 to 0xE1 |
| cfg_first | input | 8 | Requested first fetch slot |
| cfg_last | input | 8 | Last slot at which a unit may begin |
| cfg_unit | input | 2 | Unit-size code (0:8, 1:16, 2/3:32) |
| fetch_run | output | 1 | Fetch window active for the sampled slot |
| fetch_slot_en | output | 1 | Data is fetched in the sampled slot |

## Verification
The assertions take for granted that `slot_pos` advances by exactly one each clock and wraps from 0xE1 to 0, so that every line passes through slot 0 and through each start slot once. The bench meets this by driving complete lines of 226 consecutive slots. The only exception is the stretch right after reset, where non-zero slots are presented in ascending order before the first line start. Configuration values reach every clamp boundary and include start-after-stop cases. However, they change only at negative clock edges, so the slot-0 sampling is never ambiguous.

// File: rtl/fw_pkg.sv
package fw_pkg;

    typedef enum logic [1:0] {
        FW_DONE = 2'd0,
        FW_WAIT = 2'd1,
        FW_UNIT = 2'd2,
        FW_LAST = 2'd3
    } fw_state_e;

    localparam int LEN_W = 6;

    // unit-size code to slot count: 0 -> 8, 1 -> 16, otherwise 32
    function automatic logic [LEN_W-1:0] unit_len(input logic [1:0] code);
        unique case (code)
            2'd0:    return LEN_W'(8);
            2'd1:    return LEN_W'(16);
            default: return LEN_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/fw_cfg_latch.sv
module fw_cfg_latch #(
    parameter int SLOT_W    = 8,
    parameter int MIN_START = 8'h18,
    parameter int MAX_STOP  = 8'hD8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [SLOT_W-1:0]        start_in,
    input  logic [SLOT_W-1:0]        stop_in,
    input  logic [1:0]               code_in,
    output logic [SLOT_W-1:0]        start_q,
    output logic [SLOT_W-1:0]        stop_q,
    output logic [fw_pkg::LEN_W-1:0] len_q
);
    localparam logic [SLOT_W-1:0] START_FLOOR = SLOT_W'(MIN_START);
    localparam logic [SLOT_W-1:0] STOP_CEIL   = SLOT_W'(MAX_STOP);

    logic [SLOT_W-1:0] start_c, stop_c;

    always_comb begin
        start_c = (start_in < START_FLOOR) ? START_FLOOR : start_in;
        stop_c  = (stop_in > STOP_CEIL) ? STOP_CEIL : stop_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= START_FLOOR;
            stop_q  <= START_FLOOR;
            len_q   <= fw_pkg::unit_len(2'd0);
        end else if (load) begin
            start_q <= start_c;
            stop_q  <= stop_c;
            len_q   <= fw_pkg::unit_len(code_in);
        end
    end
endmodule

// File: rtl/fw_unit_cnt.sv
module fw_unit_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (ld)  cnt_q <= ld_val;
        else if (inc) cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/fw_ctrl.sv
module fw_ctrl #(
    parameter int SLOT_W     = 8,
    parameter int LINE_SLOTS = 226,
    parameter int MIN_START  = 8'h18,
    parameter int MAX_STOP   = 8'hD8,
    parameter int DATA_SLOTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_pos,
    input  logic [SLOT_W-1:0] cfg_first,
    input  logic [SLOT_W-1:0] cfg_last,
    input  logic [1:0]        cfg_unit,
    output logic              fetch_run,
    output logic              fetch_slot_en
);
    import fw_pkg::*;

    localparam int W9 = SLOT_W + 1;
    localparam logic [LEN_W-1:0]  DATA_N    = LEN_W'(DATA_SLOTS);
    localparam logic [SLOT_W-1:0] LINE_END  = SLOT_W'(LINE_SLOTS);
    localparam logic [SLOT_W-1:0] FLOOR_POS = SLOT_W'(MIN_START);
    localparam logic [SLOT_W-1:0] CEIL_POS  = SLOT_W'(MAX_STOP);

    fw_state_e         state_q, state_d;
    logic              run_d, en_d;
    logic              cfg_load, cnt_ld, cnt_inc;
    logic [LEN_W-1:0]  cnt_ld_val, cnt_q, len_q;
    logic [SLOT_W-1:0] start_q, stop_q, seen_pos_q;
    logic [W9-1:0]     pos9, stop9, len9;

    fw_cfg_latch #(
        .SLOT_W(SLOT_W), .MIN_START(MIN_START), .MAX_STOP(MAX_STOP)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .start_in(cfg_first), .stop_in(cfg_last), .code_in(cfg_unit),
        .start_q(start_q), .stop_q(stop_q), .len_q(len_q)
    );

    fw_unit_cnt #(.CNT_W(LEN_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val(cnt_ld_val),
        .inc(cnt_inc), .cnt_q(cnt_q)
    );

    assign pos9  = W9'(slot_pos);
    assign stop9 = W9'(stop_q);
    assign len9  = W9'(len_q);

    // next state and next outputs for the slot being sampled
    always_comb begin
        state_d    = state_q;
        run_d      = 1'b0;
        en_d       = 1'b0;
        cfg_load   = 1'b0;
        cnt_ld     = 1'b0;
        cnt_ld_val = '0;
        cnt_inc    = 1'b0;
        if (slot_pos == '0) begin
            cfg_load = 1'b1;
            state_d  = FW_WAIT;
        end else begin
            unique case (state_q)
                FW_DONE: ;
                FW_WAIT: begin
                    if (slot_pos == start_q && start_q <= stop_q) begin
                        run_d      = 1'b1;
                        en_d       = 1'b1;
                        cnt_ld     = 1'b1;
                        cnt_ld_val = LEN_W'(1);
                        state_d    = (pos9 + len9 > stop9) ? FW_LAST : FW_UNIT;
                    end
                end
                FW_UNIT: begin
                    run_d = 1'b1;
                    en_d  = (cnt_q < DATA_N);
                    if (cnt_q == len_q - LEN_W'(1)) begin
                        cnt_ld  = 1'b1;
                        state_d = (pos9 + W9'(1) + len9 > stop9) ? FW_LAST : FW_UNIT;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                FW_LAST: begin
                    run_d = 1'b1;
                    en_d  = 1'b1;
                    if (cnt_q == DATA_N - LEN_W'(1)) state_d = FW_DONE;
                    else                            cnt_inc = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FW_DONE;
            seen_pos_q <= '0;
        end else begin
            state_q    <= state_d;
            seen_pos_q <= slot_pos;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_run     <= 1'b0;
            fetch_slot_en <= 1'b0;
        end else begin
            fetch_run     <= run_d;
            fetch_slot_en <= en_d;
        end
    end

    AST_RUN_WITHIN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_run |-> (seen_pos_q < LINE_END)); // R1
    AST_NO_EARLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_run |-> (seen_pos_q >= FLOOR_POS)); // R3
    AST_FIRST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_run) |-> (seen_pos_q <= CEIL_POS)); // R4
    AST_EN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_slot_en |-> fetch_run); // R7
    AST_LINE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos == '0) |=> (!fetch_run && !fetch_slot_en)); // R10
endmodule

// File: tb/fw_ctrl_tb_top.sv
`timescale 1ns/1ps
module fw_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] slot_pos = 8'd0;
    logic [7:0] cfg_first = 8'h18;
    logic [7:0] cfg_last = 8'h18;
    logic [1:0] cfg_unit = 2'd0;
    logic       fetch_run, fetch_slot_en;

    int n_tests = 0;
    int n_fail = 0;
    int max_run_slot = 0;
    int last_run_slot = -1;

    always #5 clk = ~clk;

    fw_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .slot_pos(slot_pos),
        .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_unit(cfg_unit),
        .fetch_run(fetch_run), .fetch_slot_en(fetch_slot_en)
    );

    // reference model built from the requirements
    function automatic void model(input int s, input int st, input int sp,
                                  input int code, output bit r, output bit e);
        int a, b, len;
        a   = (st < 'h18) ? 'h18 : st;          // R3
        b   = (sp > 'hD8) ? 'hD8 : sp;          // R4
        len = (code == 0) ? 8 : (code == 1) ? 16 : 32;  // R2
        r = 1'b0;
        e = 1'b0;
        if (s == 0 || a > b) return;            // R10, R8
        for (int u = a; u <= b; u += len) begin // R5
            int span;
            span = (u + len > b) ? 8 : len;     // R6
            if (s >= u && s < u + span) begin
                r = 1'b1;
                e = ((s - u) < 8);              // R7
            end
        end
    endfunction

    task automatic check(input string tag, input bit act, input bit exp, input int s);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s slot %0h: actual %0b expected %0b", tag, s, act, exp);
        end
    endtask

    task automatic step(input int s);
        @(negedge clk);
        slot_pos = 8'(s);
        @(posedge clk);
        #1;
    endtask

    // one full line; expected values use st/sp/code, cfg may be altered mid-line
    task automatic run_line(input int st, input int sp, input int code, input string tag,
                            input bit alter, input int alt_st, input int alt_sp, input int alt_code);
        bit r, e;
        last_run_slot = -1;
        for (int s = 0; s < 226; s++) begin
            @(negedge clk);
            if (s == 0) begin
                cfg_first = 8'(st);
                cfg_last  = 8'(sp);
                cfg_unit  = 2'(code);
            end else if (alter && s == 'h40) begin
                cfg_first = 8'(alt_st);
                cfg_last  = 8'(alt_sp);
                cfg_unit  = 2'(alt_code);
            end
            slot_pos = 8'(s);
            @(posedge clk);
            #1;
            model(s, st, sp, code, r, e);
            check({tag, " run"}, fetch_run, r, s);
            check({tag, " en"}, fetch_slot_en, e, s);
            if (fetch_run) begin
                last_run_slot = s;
                if (s > max_run_slot) max_run_slot = s;
            end
        end
    endtask

    initial begin
        int starts[7] = '{'h00, 'h10, 'h18, 'h20, 'h3C, 'h70, 'hD8};
        int stops[7]  = '{'h10, 'h40, 'h90, 'hC8, 'hD8, 'hE0, 'hFF};
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset run", fetch_run, 1'b0, 0);
        check("R11 reset en", fetch_slot_en, 1'b0, 0);
        rst_n = 1'b1;
        // no line start yet: slots sweep through a would-be window
        cfg_first = 8'h18; cfg_last = 8'hD8; cfg_unit = 2'd0;
        for (int s = 'h10; s < 'h40; s++) begin
            step(s);
            check("R11 no line start", fetch_run, 1'b0, s);
        end

        // R6 far-right stop in 16-slot mode
        run_line('h18, 'hD8, 1, "R6 16x", 1'b0, 0, 0, 0);
        n_tests++;
        if (last_run_slot != 'hDF) begin
            n_fail++;
            $display("FAIL R6 last run slot actual %0h expected df", last_run_slot);
        end
        // R6 32-slot mode with stop 0xC8: last unit at 0xB8 runs to 0xBF
        run_line('h18, 'hC8, 2, "R6 32x", 1'b0, 0, 0, 0);
        n_tests++;
        if (last_run_slot != 'hBF) begin
            n_fail++;
            $display("FAIL R6 last run slot actual %0h expected bf", last_run_slot);
        end
        // R8 start beyond stop
        run_line('h80, 'h40, 1, "R8 empty", 1'b0, 0, 0, 0);
        n_tests++;
        if (last_run_slot != -1) begin
            n_fail++;
            $display("FAIL R8 run seen actual %0h expected none", last_run_slot);
        end
        // R9 mid-line change ignored, then honoured on the next line
        run_line('h30, 'h90, 0, "R9 hold", 1'b1, 'h18, 'hD8, 2);
        run_line('h18, 'hD8, 2, "R9 next", 1'b0, 0, 0, 0);

        // sweep of all unit codes, start and stop values (R2 R3 R4 R5 R6 R7 R10)
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    run_line(starts[i], stops[j], c, "R2 R3 R4 R5 R6 R7 R10", 1'b0, 0, 0, 0);

        n_tests++;
        if (max_run_slot >= 'hE2) begin
            n_fail++;
            $display("FAIL R1 max run slot actual %0h expected below e2", max_run_slot);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule